// File: doc/BRIEF.md
# CAN FD Operation Mode Switcher

This block holds the operating mode of a CAN protocol controller: classic ISO 11898-1 operation, CAN FD, or CAN FD with bit rate switching. Software writes a 2-bit mode request and a 2-bit mode permission field through a single-cycle register write port. The request is not applied when it is written. It waits until the protocol engine reports an idle gap between frames, so the mode never changes inside a frame.

At an idle strobe the block checks the pending request against the permission field. If the permission field allows the mode, the block updates its two mode flags (FD on, bit rate switching on) and clears the request back to "no change". If the mode is not allowed, the request stays pending and the flags keep their values. A later write or a later change of permission decides what happens to it. The flags drive the protocol engine directly and can also be read back.

Top module: `canfd_mode_ctrl`

## Requirements
- R1: After reset the FD flag and the BRS flag are both 0 (classic operation) and the pending request reads 00.
- R2: An applied request sets the flags as follows: 01 gives FD=1 and BRS=0, 10 gives FD=1 and BRS=1, and 11 gives FD=0 and BRS=0. BRS is never 1 while FD is 0.
- R3: The flags change only in the cycle after an idle strobe that applies a request. They hold their values in every other cycle.
- R4: When a request is applied, the pending request field reads 00 from the next cycle on.
- R5: At an idle strobe, a request that the permission field does not allow stays pending, and the flags do not change.
- R6: Permission encoding, written with every register write: 00 allows only classic operation, 01 also allows CAN FD without bit rate switching, and 10 or 11 allows FD both with and without bit rate switching.
- R7: A request for classic operation (11) is applied at an idle strobe for every permission value.
- R8: A register write with request 00 leaves the pending request unchanged. A write with a nonzero request replaces the pending request.
- R9: When a write and an idle strobe fall in the same cycle, the idle strobe evaluates the request and permission held before that write. A nonzero written request becomes the pending request and is evaluated at the next idle strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| arst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en_i | input | 1 | Register write strobe |
| wr_req_i | input | 2 | Mode request value written |
| wr_perm_i | input | 2 | Mode permission value written |
| idle_i | input | 1 | Idle-gap strobe from the protocol engine |
| req_o | output | 2 | Pending mode request (00 = none) |
| perm_o | output | 2 | Current permission field |
| fd_on_o | output | 1 | FD operation flag and engine enable |
| brs_on_o | output | 1 | Bit rate switching flag and engine enable |

## Verification
A register write and an idle strobe can fall in the same cycle. The idle strobe then applies or rejects the old request while the write replaces it. The bench sets up this collision three ways: an old request that is rejected while a nonzero write replaces it, an old request that is applied while a different nonzero write replaces it, and an old request that is applied while a write of 00 arrives. In each case it checks that the flags follow the old request and permission, and that the request field holds the new value or 00. It then checks that the following idle strobe applies the newly written request.

// File: rtl/canfd_mode_pkg.sv
package canfd_mode_pkg;

  localparam int FIELD_W = 2;

  localparam logic [FIELD_W-1:0] REQ_NONE    = 2'b00;
  localparam logic [FIELD_W-1:0] REQ_FD      = 2'b01;
  localparam logic [FIELD_W-1:0] REQ_FD_BRS  = 2'b10;
  localparam logic [FIELD_W-1:0] REQ_CLASSIC = 2'b11;

  typedef struct packed {
    logic fd;
    logic brs;
  } mode_flags_t;

  // Permission check of a request against the permission field.
  function automatic logic req_permitted(input logic [FIELD_W-1:0] req,
                                         input logic [FIELD_W-1:0] perm);
    logic ok;
    unique case (req)
      REQ_CLASSIC: ok = 1'b1;
      REQ_FD:      ok = (perm != 2'b00);
      REQ_FD_BRS:  ok = perm[1];
      default:     ok = 1'b0;
    endcase
    return ok;
  endfunction

  // Flags that a request selects.
  function automatic mode_flags_t req_to_flags(input logic [FIELD_W-1:0] req);
    mode_flags_t f;
    f.fd  = (req == REQ_FD) || (req == REQ_FD_BRS);
    f.brs = (req == REQ_FD_BRS);
    return f;
  endfunction

endpackage

// File: rtl/canfd_rst_sync.sv
module canfd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/canfd_req_reg.sv
module canfd_req_reg
  import canfd_mode_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [FIELD_W-1:0] wr_req_i,
  input  logic [FIELD_W-1:0] wr_perm_i,
  input  logic               apply_i,
  output logic [FIELD_W-1:0] req_o,
  output logic [FIELD_W-1:0] perm_o
);
  logic [FIELD_W-1:0] req_q, req_d;
  logic [FIELD_W-1:0] perm_q;
  logic               req_load;

  // A nonzero write wins over the clear of an applied request.
  always_comb begin
    req_d    = req_q;
    req_load = 1'b0;
    if (wr_en_i && (wr_req_i != REQ_NONE)) begin
      req_d    = wr_req_i;
      req_load = 1'b1;
    end else if (apply_i) begin
      req_d    = REQ_NONE;
      req_load = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       req_q <= REQ_NONE;
    else if (req_load) req_q <= req_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      perm_q <= '0;
    else if (wr_en_i) perm_q <= wr_perm_i;
  end

  assign req_o  = req_q;
  assign perm_o = perm_q;
endmodule

// File: rtl/canfd_mode_state.sv
module canfd_mode_state
  import canfd_mode_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               apply_i,
  input  logic [FIELD_W-1:0] req_i,
  output logic               fd_o,
  output logic               brs_o
);
  mode_flags_t flags_q, flags_d;

  always_comb begin
    flags_d = req_to_flags(req_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flags_q <= '0;
    else if (apply_i) flags_q <= flags_d;
  end

  assign fd_o  = flags_q.fd;
  assign brs_o = flags_q.brs;
endmodule

// File: rtl/canfd_mode_ctrl.sv
module canfd_mode_ctrl
  import canfd_mode_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               arst_ni,
  input  logic               wr_en_i,
  input  logic [FIELD_W-1:0] wr_req_i,
  input  logic [FIELD_W-1:0] wr_perm_i,
  input  logic               idle_i,
  output logic [FIELD_W-1:0] req_o,
  output logic [FIELD_W-1:0] perm_o,
  output logic               fd_on_o,
  output logic               brs_on_o
);
  logic               rst_sync_n;
  logic [FIELD_W-1:0] req_cur;
  logic [FIELD_W-1:0] perm_cur;
  logic               apply;

  canfd_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk_i   (clk_i),
    .arst_ni (arst_ni),
    .rst_no  (rst_sync_n)
  );

  // The strobe sees the registered request and permission, so a
  // same-cycle write is evaluated at the following strobe.
  always_comb begin
    apply = idle_i && (req_cur != REQ_NONE) && req_permitted(req_cur, perm_cur);
  end

  canfd_req_reg i_req_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .wr_en_i   (wr_en_i),
    .wr_req_i  (wr_req_i),
    .wr_perm_i (wr_perm_i),
    .apply_i   (apply),
    .req_o     (req_cur),
    .perm_o    (perm_cur)
  );

  canfd_mode_state i_mode_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .apply_i (apply),
    .req_i   (req_cur),
    .fd_o    (fd_on_o),
    .brs_o   (brs_on_o)
  );

  assign req_o  = req_cur;
  assign perm_o = perm_cur;
endmodule

// File: rtl/canfd_mode_ctrl_chk.sv
module canfd_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_req,
  input logic       idle,
  input logic [1:0] req,
  input logic [1:0] perm,
  input logic       fd,
  input logic       brs
);
  logic ok;
  assign ok = (req == 2'b11) || ((req == 2'b01) && (perm != 2'b00)) ||
              ((req == 2'b10) && perm[1]);

  // R2
  brs_needs_fd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brs |-> fd);

  // R3
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> ($stable(fd) && $stable(brs)));

  // R4
  req_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && ok && (req != 2'b00) && !wr_en) |=> (req == 2'b00));

  // R5
  req_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !ok && !wr_en) |=> ($stable(req) && $stable(fd) && $stable(brs)));

  // R8
  zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_req == 2'b00) && !idle) |=> $stable(req));

  // R9
  new_req_loaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_req != 2'b00)) |=> (req == $past(wr_req)));
endmodule

bind canfd_mode_ctrl canfd_mode_ctrl_chk i_chk (
  .clk    (clk_i),
  .rst_n  (rst_sync_n),
  .wr_en  (wr_en_i),
  .wr_req (wr_req_i),
  .idle   (idle_i),
  .req    (req_o),
  .perm   (perm_o),
  .fd     (fd_on_o),
  .brs    (brs_on_o)
);

// File: tb/test_canfd_mode_ctrl.sv
`timescale 1ns/1ps
module test_canfd_mode_ctrl;
  logic       clk;
  logic       arst_n;
  logic       wr_en;
  logic [1:0] wr_req;
  logic [1:0] wr_perm;
  logic       idle;
  logic [1:0] req;
  logic [1:0] perm;
  logic       fd_on;
  logic       brs_on;

  int applied = 0;
  int bad     = 0;
  bit done    = 0;

  canfd_mode_ctrl i_canfd_mode_ctrl (
    .clk_i(clk), .arst_ni(arst_n), .wr_en_i(wr_en), .wr_req_i(wr_req),
    .wr_perm_i(wr_perm), .idle_i(idle), .req_o(req), .perm_o(perm),
    .fd_on_o(fd_on), .brs_on_o(brs_on)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {tag[3:0], wr, wreq[1:0], wperm[1:0], idle, exp_fd, exp_brs, exp_req[1:0]}
  localparam int NV = 17;
  localparam logic [13:0] VEC [NV] = '{
    {4'd3, 1'b1, 2'b01, 2'b01, 1'b0, 1'b0, 1'b0, 2'b01}, // R3 write, no idle
    {4'd2, 1'b0, 2'b00, 2'b00, 1'b1, 1'b1, 1'b0, 2'b00}, // R2 R4 FD applied
    {4'd3, 1'b1, 2'b10, 2'b01, 1'b0, 1'b1, 1'b0, 2'b10}, // R3
    {4'd6, 1'b0, 2'b00, 2'b00, 1'b1, 1'b1, 1'b0, 2'b10}, // R6 R5 BRS not allowed
    {4'd8, 1'b1, 2'b00, 2'b10, 1'b0, 1'b1, 1'b0, 2'b10}, // R8 zero write keeps
    {4'd2, 1'b0, 2'b00, 2'b00, 1'b1, 1'b1, 1'b1, 2'b00}, // R2 BRS applied
    {4'd8, 1'b1, 2'b11, 2'b00, 1'b0, 1'b1, 1'b1, 2'b11}, // R8 replace
    {4'd7, 1'b0, 2'b00, 2'b00, 1'b1, 1'b0, 1'b0, 2'b00}, // R7 classic, perm 00
    {4'd8, 1'b1, 2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 2'b01}, // R8
    {4'd5, 1'b0, 2'b00, 2'b00, 1'b1, 1'b0, 1'b0, 2'b01}, // R5 R6 FD not allowed
    {4'd9, 1'b1, 2'b11, 2'b00, 1'b1, 1'b0, 1'b0, 2'b11}, // R9 reject old, load new
    {4'd7, 1'b0, 2'b00, 2'b00, 1'b1, 1'b0, 1'b0, 2'b00}, // R7
    {4'd8, 1'b1, 2'b01, 2'b11, 1'b0, 1'b0, 1'b0, 2'b01}, // R8
    {4'd9, 1'b1, 2'b10, 2'b11, 1'b1, 1'b1, 1'b0, 2'b10}, // R9 apply old, load new
    {4'd9, 1'b0, 2'b00, 2'b00, 1'b1, 1'b1, 1'b1, 2'b00}, // R9 new applied next
    {4'd3, 1'b1, 2'b11, 2'b11, 1'b0, 1'b1, 1'b1, 2'b11}, // R3 held during frame
    {4'd9, 1'b1, 2'b00, 2'b11, 1'b1, 1'b0, 1'b0, 2'b00}  // R9 apply with zero write
  };

  task automatic check(input string tag, input logic [3:0] exp);
    applied++;
    if ({fd_on, brs_on, req} !== exp) begin
      bad++;
      $display("FAIL %s: fd/brs/req actual %b%b %b expected %b%b %b", tag,
               fd_on, brs_on, req, exp[3], exp[2], exp[1:0]);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    arst_n = 1'b0; wr_en = 1'b0; wr_req = '0; wr_perm = '0; idle = 1'b0;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset state", 4'b0000);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      wr_en   = VEC[i][9];
      wr_req  = VEC[i][8:7];
      wr_perm = VEC[i][6:5];
      idle    = VEC[i][4];
      @(posedge clk); #1;
      check($sformatf("R%0d vector %0d", VEC[i][13:10], i), VEC[i][3:0]);
    end
    @(negedge clk);
    wr_en = 1'b0; wr_req = '0; idle = 1'b0;

    // R3: idle with nothing pending leaves flags alone
    @(negedge clk); wr_en = 1'b1; wr_req = 2'b10; wr_perm = 2'b10;
    @(negedge clk); wr_en = 1'b0; idle = 1'b1;
    @(negedge clk); idle = 1'b0;
    check("R2 BRS mode before idle test", 4'b1100);
    @(negedge clk); idle = 1'b1;
    @(negedge clk); idle = 1'b0;
    check("R3 idle without request", 4'b1100);

    // R1: asynchronous reset mid-operation
    @(negedge clk); wr_en = 1'b1; wr_req = 2'b11;
    @(negedge clk); wr_en = 1'b0;
    arst_n = 1'b0; #1;
    check("R1 async reset", 4'b0000);
    applied++;
    if (perm !== 2'b00) begin
      bad++;
      $display("FAIL R1 perm after reset: actual %b expected 00", perm);
    end
    @(negedge clk); arst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", 4'b0000);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule